// File: doc/BRIEF.md
# DMA Channel Flag Unit

This block keeps the interrupt and status flags of a four-channel DMA controller. The channel engines drive one-cycle event pulses into it: block start, block done, transaction done, error, channel disable, block waiting and abort. Each channel also supplies its endless-repeat setting. From these pulses the unit keeps four bits per channel: error, complete, busy and pending.

Software sees the flags through two 8-bit registers on a small CPU register bus. The interrupt flag register at offset 0x04 holds the error and complete flags, and writing a one to a bit clears that bit. The status register at offset 0x05 holds the busy and pending bits and is read-only. Each channel drives two interrupt requests, one for error and one for complete. Each request is gated by its own enable input. Reads come back one cycle after the request.

Top module: `dma_flag_unit`

## Requirements
- R1: After a synchronous reset, both registers read 0x00 and every interrupt request output is low.
- R2: An error pulse on channel n sets bit 4+n of the interrupt flag register (offset 0x04). Writing a one to that bit clears it.
- R3: A transaction-done pulse on channel n sets bit n of the interrupt flag register. Writing a one to that bit clears it.
- R4: When the endless-repeat input of channel n is high, a block-done pulse also sets bit n of the interrupt flag register. When that input is low, a block-done pulse leaves bit n unchanged.
- R5: A zero bit in write data leaves the matching flag unchanged. Writing 0x00 changes nothing, and a write clears only the bits that are one.
- R6: If a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R7: A start pulse on channel n sets busy bit 4+n of the status register (offset 0x05). Busy clears on a disable pulse, on an error pulse, or on any event that sets the complete flag. If a start and a clearing event arrive in the same cycle, busy ends up clear.
- R8: A block-waiting pulse on channel n sets pending bit n of the status register. Pending clears on a start pulse or an abort pulse. If a set and a clear arrive in the same cycle, pending ends up clear.
- R9: Writes to the status register offset change no flag in either register.
- R10: A read with select high and write low returns the addressed register on `bus_rdata` after the next rising edge, and the output holds between reads. Any offset other than 0x04 and 0x05 reads 0x00.
- R11: `irq_err[n]` is high exactly while the error flag of channel n and `irq_en_err[n]` are both high. `irq_cpl[n]` follows the same rule with the complete flag and `irq_en_cpl[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 4 | Per-channel block start pulse |
| ev_blk_done | input | 4 | Per-channel block done pulse |
| ev_txn_done | input | 4 | Per-channel transaction done pulse |
| ev_err | input | 4 | Per-channel error pulse |
| ev_dis | input | 4 | Per-channel disable pulse |
| ev_pend | input | 4 | Per-channel block waiting pulse |
| ev_abort | input | 4 | Per-channel abort pulse |
| rpt_unlim | input | 4 | Per-channel endless-repeat setting |
| irq_en_err | input | 4 | Per-channel error request enable |
| irq_en_cpl | input | 4 | Per-channel complete request enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_err | output | 4 | Per-channel error interrupt request |
| irq_cpl | output | 4 | Per-channel complete interrupt request |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. These are a hardware set meeting a software clear on one flag, a start arriving with a disable, and a block-waiting pulse arriving with a start. To make these happen, the bench drives the event pulse and the bus write, or both event pulses, on the same falling edge so that they are captured on the same rising edge. It then reads both registers to see which side won. Endless repeat is covered by sending block-done pulses with the setting both low and high. In the second case the bench also checks that busy drops on that event.

// File: rtl/dmaflag_pkg.sv
package dmaflag_pkg;

    localparam int NCH   = 4;
    localparam int REG_W = 2 * NCH;

    localparam logic [7:0] OFS_IFLAG = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h05;

    typedef struct packed {
        logic start;
        logic blk_done;
        logic txn_done;
        logic err;
        logic dis;
        logic pend;
        logic abort;
    } chan_ev_t;

    typedef struct packed {
        logic err;
        logic cpl;
        logic busy;
        logic pend;
    } chan_flags_t;

    function automatic logic [REG_W-1:0] join_halves(input logic [NCH-1:0] hi,
                                                     input logic [NCH-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic next_flag(input logic cur, input logic set, input logic clr,
                                       input logic set_wins);
        logic r;
        if (set_wins) r = set ? 1'b1 : (clr ? 1'b0 : cur);
        else          r = clr ? 1'b0 : (set ? 1'b1 : cur);
        return r;
    endfunction

endpackage

// File: rtl/dmaflag_chan.sv
module dmaflag_chan
    import dmaflag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chan_ev_t    ev,
    input  logic        rpt_unlim,
    input  logic        clr_err,
    input  logic        clr_cpl,
    output chan_flags_t flags
);

    chan_flags_t q, d;
    logic        cpl_hit;
    logic        busy_end;
    logic        pend_end;

    always_comb begin
        cpl_hit  = ev.txn_done | (rpt_unlim & ev.blk_done);
        busy_end = ev.dis | ev.err | cpl_hit;
        pend_end = ev.start | ev.abort;
        d.err    = next_flag(q.err,  ev.err,   clr_err,  1'b1);
        d.cpl    = next_flag(q.cpl,  cpl_hit,  clr_cpl,  1'b1);
        d.busy   = next_flag(q.busy, ev.start, busy_end, 1'b0);
        d.pend   = next_flag(q.pend, ev.pend,  pend_end, 1'b0);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign flags = q;

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ev.err |=> flags.err);                                          // R6
    AST_ERR_W1C: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !ev.err) |=> !flags.err);                           // R2
    AST_RPT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (rpt_unlim && ev.blk_done) |=> flags.cpl);                      // R4
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (ev.dis || ev.err || ev.txn_done) |=> !flags.busy);             // R7
    AST_PEND_ENDS: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.abort) |=> !flags.pend);                        // R8

endmodule

// File: rtl/dmaflag_regif.sv
module dmaflag_regif
    import dmaflag_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  iflags,
    input  logic [REG_W-1:0]  status,
    output logic [NCH-1:0]    clr_err,
    output logic [NCH-1:0]    clr_cpl,
    output logic [REG_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] A_IFLAG = ADDR_W'(OFS_IFLAG);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    logic             wr_if;
    logic             rd_go;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rd_q;

    assign wr_if = bus_sel && bus_wr && (bus_addr == A_IFLAG);
    assign rd_go = bus_sel && !bus_wr;

    always_comb begin
        clr_err = wr_if ? bus_wdata[REG_W-1:NCH] : '0;
        clr_cpl = wr_if ? bus_wdata[NCH-1:0]     : '0;
    end

    always_comb begin
        case (bus_addr)
            A_IFLAG: rd_mux = iflags;
            A_STAT:  rd_mux = status;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_go) rd_q <= rd_mux;
    end

    assign bus_rdata = rd_q;

    AST_RD_IFLAG: assert property (@(posedge clk) disable iff (rst)
        (rd_go && bus_addr == A_IFLAG) |=> bus_rdata == $past(iflags));  // R10
    AST_RD_STAT: assert property (@(posedge clk) disable iff (rst)
        (rd_go && bus_addr == A_STAT) |=> bus_rdata == $past(status));   // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(bus_rdata));                                  // R10
    AST_STAT_RO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == A_STAT) |-> (clr_err == '0 && clr_cpl == '0)); // R9

endmodule

// File: rtl/dma_flag_unit.sv
module dma_flag_unit
    import dmaflag_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ev_start,
    input  logic [NCH-1:0]    ev_blk_done,
    input  logic [NCH-1:0]    ev_txn_done,
    input  logic [NCH-1:0]    ev_err,
    input  logic [NCH-1:0]    ev_dis,
    input  logic [NCH-1:0]    ev_pend,
    input  logic [NCH-1:0]    ev_abort,
    input  logic [NCH-1:0]    rpt_unlim,
    input  logic [NCH-1:0]    irq_en_err,
    input  logic [NCH-1:0]    irq_en_cpl,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq_err,
    output logic [NCH-1:0]    irq_cpl
);

    logic [NCH-1:0]   clr_err, clr_cpl;
    logic [NCH-1:0]   err_v, cpl_v, busy_v, pend_v;
    logic [REG_W-1:0] iflags, status;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        chan_ev_t    ev;
        chan_flags_t fl;

        assign ev = '{start:    ev_start[n],
                      blk_done: ev_blk_done[n],
                      txn_done: ev_txn_done[n],
                      err:      ev_err[n],
                      dis:      ev_dis[n],
                      pend:     ev_pend[n],
                      abort:    ev_abort[n]};

        dmaflag_chan i_chan (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev),
            .rpt_unlim (rpt_unlim[n]),
            .clr_err   (clr_err[n]),
            .clr_cpl   (clr_cpl[n]),
            .flags     (fl)
        );

        assign err_v[n]  = fl.err;
        assign cpl_v[n]  = fl.cpl;
        assign busy_v[n] = fl.busy;
        assign pend_v[n] = fl.pend;
    end

    assign iflags = join_halves(err_v, cpl_v);
    assign status = join_halves(busy_v, pend_v);

    dmaflag_regif #(.ADDR_W(ADDR_W)) i_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .iflags    (iflags),
        .status    (status),
        .clr_err   (clr_err),
        .clr_cpl   (clr_cpl),
        .bus_rdata (bus_rdata)
    );

    assign irq_err = err_v & irq_en_err;
    assign irq_cpl = cpl_v & irq_en_cpl;

    AST_IRQ_RESET: assert property (@(posedge clk)
        $past(rst) |-> (irq_err == '0 && irq_cpl == '0));                // R1
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_err[0]) |-> ($past(ev_err[0]) || $rose(irq_en_err[0]))); // R11

endmodule

// File: tb/test_dma_flag_unit.sv
`timescale 1ns/1ps
module test_dma_flag_unit;

    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] ev_start = '0, ev_blk_done = '0, ev_txn_done = '0, ev_err = '0;
    logic [NCH-1:0] ev_dis = '0, ev_pend = '0, ev_abort = '0;
    logic [NCH-1:0] rpt_unlim = '0, irq_en_err = '1, irq_en_cpl = '1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NCH-1:0] irq_err, irq_cpl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dma_flag_unit i_dma_flag_unit (
        .clk(clk), .rst(rst),
        .ev_start(ev_start), .ev_blk_done(ev_blk_done), .ev_txn_done(ev_txn_done),
        .ev_err(ev_err), .ev_dis(ev_dis), .ev_pend(ev_pend), .ev_abort(ev_abort),
        .rpt_unlim(rpt_unlim), .irq_en_err(irq_en_err), .irq_en_cpl(irq_en_cpl),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_err(irq_err), .irq_cpl(irq_cpl)
    );

    localparam int K_START = 0, K_BLK = 1, K_TXN = 2, K_ERR = 3,
                   K_DIS = 4, K_PEND = 5, K_ABORT = 6, K_NONE = -1;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic set_ev(input int kind, input int ch);
        case (kind)
            K_START: ev_start[ch]    = 1'b1;
            K_BLK:   ev_blk_done[ch] = 1'b1;
            K_TXN:   ev_txn_done[ch] = 1'b1;
            K_ERR:   ev_err[ch]      = 1'b1;
            K_DIS:   ev_dis[ch]      = 1'b1;
            K_PEND:  ev_pend[ch]     = 1'b1;
            K_ABORT: ev_abort[ch]    = 1'b1;
            default: ;
        endcase
    endtask

    task automatic clear_ev();
        ev_start = '0; ev_blk_done = '0; ev_txn_done = '0; ev_err = '0;
        ev_dis = '0; ev_pend = '0; ev_abort = '0;
    endtask

    task automatic fire(input int ka, input int kb, input int ch);
        @(negedge clk);
        set_ev(ka, ch);
        set_ev(kb, ch);
        @(posedge clk); #1;
        clear_ev();
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_regs(input string tag, input logic [7:0] ifl, input logic [7:0] st);
        logic [7:0] d;
        rd(8'h04, d); check({tag, " iflags"}, d, ifl);
        rd(8'h05, d); check({tag, " status"}, d, st);
    endtask

    task automatic t_reset();
        expect_regs("R1 reset", 8'h00, 8'h00);
        check("R1 irq_err", {4'h0, irq_err}, 8'h00);
        check("R1 irq_cpl", {4'h0, irq_cpl}, 8'h00);
    endtask

    task automatic t_error();
        fire(K_ERR, K_NONE, 2);
        expect_regs("R2 err set", 8'h40, 8'h00);
        check("R11 irq_err on", {4'h0, irq_err}, 8'h04);
        irq_en_err[2] = 1'b0; #1;
        check("R11 irq_err masked", {4'h0, irq_err}, 8'h00);
        irq_en_err[2] = 1'b1;
        wr(8'h04, 8'h40);
        expect_regs("R2 err cleared", 8'h00, 8'h00);
    endtask

    task automatic t_complete();
        fire(K_TXN, K_NONE, 0);
        expect_regs("R3 cpl set", 8'h01, 8'h00);
        check("R11 irq_cpl on", {4'h0, irq_cpl}, 8'h01);
        wr(8'h04, 8'h01);
        expect_regs("R3 cpl cleared", 8'h00, 8'h00);
        check("R11 irq_cpl off", {4'h0, irq_cpl}, 8'h00);
    endtask

    task automatic t_repeat();
        rpt_unlim[3] = 1'b0;
        fire(K_BLK, K_NONE, 3);
        expect_regs("R4 block without repeat", 8'h00, 8'h00);
        rpt_unlim[3] = 1'b1;
        fire(K_START, K_NONE, 3);
        fire(K_BLK, K_NONE, 3);
        expect_regs("R4 block with repeat", 8'h08, 8'h00);
        wr(8'h04, 8'h08);
        rpt_unlim[3] = 1'b0;
    endtask

    task automatic t_zero_write();
        fire(K_ERR, K_TXN, 1);
        expect_regs("R5 setup", 8'h22, 8'h00);
        wr(8'h04, 8'h00);
        expect_regs("R5 zero write", 8'h22, 8'h00);
        wr(8'h04, 8'h01);
        expect_regs("R5 other channel write", 8'h22, 8'h00);
        wr(8'h04, 8'h20);
        expect_regs("R5 partial clear", 8'h02, 8'h00);
        wr(8'h04, 8'h02);
    endtask

    task automatic t_collision();
        @(negedge clk);
        ev_err[1] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 8'h20;
        @(posedge clk); #1;
        clear_ev(); bus_sel = 1'b0; bus_wr = 1'b0;
        expect_regs("R6 set beats clear", 8'h20, 8'h00);
        wr(8'h04, 8'h20);
    endtask

    task automatic t_busy();
        fire(K_START, K_NONE, 1);
        expect_regs("R7 busy set", 8'h00, 8'h20);
        fire(K_DIS, K_NONE, 1);
        expect_regs("R7 busy off by disable", 8'h00, 8'h00);
        fire(K_START, K_NONE, 1);
        fire(K_ERR, K_NONE, 1);
        expect_regs("R7 busy off by error", 8'h20, 8'h00);
        wr(8'h04, 8'h20);
        fire(K_START, K_NONE, 1);
        fire(K_TXN, K_NONE, 1);
        expect_regs("R7 busy off by complete", 8'h02, 8'h00);
        wr(8'h04, 8'h02);
        fire(K_START, K_DIS, 1);
        expect_regs("R7 start with disable", 8'h00, 8'h00);
        rpt_unlim[1] = 1'b1;
        fire(K_START, K_NONE, 1);
        fire(K_BLK, K_NONE, 1);
        expect_regs("R7 busy off by repeat block", 8'h02, 8'h00);
        wr(8'h04, 8'h02);
        rpt_unlim[1] = 1'b0;
    endtask

    task automatic t_pending();
        fire(K_PEND, K_NONE, 0);
        expect_regs("R8 pend set", 8'h00, 8'h01);
        fire(K_START, K_NONE, 0);
        expect_regs("R8 pend off by start", 8'h00, 8'h10);
        fire(K_DIS, K_NONE, 0);
        fire(K_PEND, K_NONE, 0);
        fire(K_ABORT, K_NONE, 0);
        expect_regs("R8 pend off by abort", 8'h00, 8'h00);
        fire(K_PEND, K_START, 0);
        expect_regs("R8 pend with start", 8'h00, 8'h10);
        fire(K_DIS, K_NONE, 0);
    endtask

    task automatic t_status_ro();
        fire(K_START, K_NONE, 2);
        fire(K_ERR, K_NONE, 3);
        wr(8'h05, 8'hFF);
        expect_regs("R9 status write ignored", 8'h80, 8'h40);
        fire(K_DIS, K_NONE, 2);
        wr(8'h04, 8'h80);
    endtask

    task automatic t_read_path();
        logic [7:0] d;
        fire(K_START, K_NONE, 2);
        rd(8'h05, d);
        check("R10 status read", d, 8'h40);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h04;
        #1;
        check("R10 old data before edge", bus_rdata, 8'h40);
        @(posedge clk); #1;
        check("R10 new data after edge", bus_rdata, 8'h00);
        bus_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 hold between reads", bus_rdata, 8'h00);
        rd(8'h07, d);
        check("R10 unmapped offset", d, 8'h00);
        fire(K_DIS, K_NONE, 2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_error();
        t_complete();
        t_repeat();
        t_zero_write();
        t_collision();
        t_busy();
        t_pending();
        t_status_ro();
        t_read_path();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule